// File: doc/BRIEF.md
# Packetized Memory Request Controller with Retry

This block sits between a host and a byte-wide packetized memory channel. When the host hands it a read or write request, it sends a six-byte request packet onto the channel, one byte per clock. It then samples a two-bit acknowledge code at a fixed cycle after the packet. While that acknowledge is still pending, a write already has its data going out on the channel.

On a positive acknowledge the controller finishes the burst. For a read it passes incoming bytes to the host. For a write it keeps driving bytes fetched from a host-side buffer. On a negative acknowledge it releases the channel and waits until a fixed interval has passed since the start of the refused packet. It then sends the whole packet again. A responder refuses an access when the page is not open or when a refresh is under way. After a bounded number of reissues that are all refused, the controller gives up and flags an error.

All delays are given in clock cycles and counted from the last packet byte. The write buffer is read through an index port, so the data can be replayed on every attempt without a copy inside the block.

Top module: `pkt_mem_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle, including after reset. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: The six packet bytes go out on consecutive cycles, starting the cycle after acceptance, with `bus_oe` high. They are sent in this order:
  - byte 0: the opcode in bits 7:4 (read = 4'h1, write = 4'h2) and address bits 35:32 in bits 3:0;
  - byte 1: the burst length minus one;
  - bytes 2 to 5: address bits 31:0, most significant byte first.
- R3: `ack_in` is sampled ACK_DLY cycles after the last packet byte. Only the code 2'b01 counts as positive; every other code (for example 2'b10 or 2'b11) counts as negative.
- R4: For an accepted read, `bus_in` is passed to `rd_data` starting RD_DLY cycles after the last packet byte, one byte per cycle. `rd_valid` is high for each byte and `rd_idx` counts 0 up to length minus 1.
- R5: For a write, byte k of the burst goes out on `bus_out` WR_OFS+k cycles after the last packet byte, with `wr_idx` = k. This starts before the acknowledge slot and runs to the end of the burst if the acknowledge is positive.
- R6: After a negative acknowledge, `bus_oe` is low from the cycle after the acknowledge slot until the packet is sent again. Any write data not yet sent is dropped.
- R7: After a negative acknowledge (with reissues left), byte 0 of the packet is sent again RETRY_WAIT cycles after byte 0 of the refused attempt.
- R8: If the attempt after MAX_RETRY reissues is also refused, `err` pulses for one cycle, the cycle after the acknowledge slot. `done` stays low and the controller returns to idle.
- R9: `done` pulses for one cycle, the cycle after the last burst byte. For a write whose burst ended before the acknowledge slot, it pulses the cycle after that slot instead.
- R10: The burst length is `req_len_m1`+1, anywhere from 1 to 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 36 | Request address |
| req_len_m1 | input | 8 | Burst length minus one |
| wr_idx | output | 8 | Index of the write byte wanted from the host buffer |
| wr_data | input | 8 | Host buffer byte at `wr_idx` (combinational) |
| rd_valid | output | 1 | A read byte is on `rd_data` |
| rd_idx | output | 8 | Burst position of the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse when a transaction completes |
| err | output | 1 | One-cycle pulse when the retry limit is exhausted |
| bus_out | output | 8 | Channel byte driven by the controller |
| bus_oe | output | 1 | Controller drives the channel |
| bus_in | input | 8 | Channel byte from the responder |
| ack_in | input | 2 | Acknowledge code from the responder |

## Verification
The hardest situation to reach is a write that is refused partway through its burst. In that case data has already been driven past the acknowledge slot's cycle and must stop at once. The reissue that follows must replay the packet and restart the data from index 0.

The bench reaches this case with a 20-byte write whose first attempt receives a negative code. It checks every cycle of that attempt and the next against a responder model that counts cycles from the first packet byte. The same model refuses a read four times in a row to exhaust the retry budget, and returns the undefined code 2'b11 to show that it counts as a refusal.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int PKT_BYTES = 6;
    localparam int ADDR_W    = 36;
    localparam int LEN_W     = 8;

    localparam logic [3:0] OPC_READ  = 4'h1;
    localparam logic [3:0] OPC_WRITE = 4'h2;
    localparam logic [1:0] ACK_GOOD  = 2'b01;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ATTEMPT,
        PH_BACKOFF
    } phase_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len_m1;
    } mreq_t;

    function automatic logic [3:0] opc_of(input logic is_write);
        return is_write ? OPC_WRITE : OPC_READ;
    endfunction

endpackage

// File: rtl/pmc_pkt_tx.sv
module pmc_pkt_tx
    import pmc_pkg::*;
(
    input  mreq_t       req,
    input  logic [2:0]  idx,
    input  logic        active,
    output logic        drive,
    output logic [7:0]  data
);
    logic [7:0] bytes_q [8];

    assign bytes_q[0] = {opc_of(req.write), req.addr[ADDR_W-1:32]};
    assign bytes_q[1] = req.len_m1;

    for (genvar g = 0; g < 4; g++) begin : g_addr
        assign bytes_q[2+g] = req.addr[8*(3-g) +: 8];
    end

    assign bytes_q[6] = 8'h00;
    assign bytes_q[7] = 8'h00;

    assign drive = active;
    assign data  = active ? bytes_q[idx] : 8'h00;
endmodule

// File: rtl/pmc_burst_win.sv
module pmc_burst_win #(
    parameter int TICK_W = 9,
    parameter int START  = 7
) (
    input  logic [TICK_W-1:0] tick,
    input  logic [7:0]        len_m1,
    input  logic              en,
    output logic              in_win,
    output logic [7:0]        idx,
    output logic              last
);
    localparam logic [TICK_W-1:0] START_T = TICK_W'(START);

    logic [TICK_W-1:0] rel;
    logic [TICK_W-1:0] len_ext;

    assign rel     = tick - START_T;
    assign len_ext = {{(TICK_W-8){1'b0}}, len_m1};
    assign in_win  = en && (tick >= START_T) && (rel <= len_ext);
    assign idx     = rel[7:0];
    assign last    = in_win && (rel == len_ext);
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int TICK_W     = 9,
    parameter int ACK_T      = 13,
    parameter int WR_T       = 7,
    parameter int RETRY_WAIT = 32,
    parameter int MAX_RETRY  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  mreq_t             req_in,
    input  logic [1:0]        ack_in,
    input  logic              last_w,
    input  logic              last_r,
    output phase_e            phase,
    output logic [TICK_W-1:0] tick,
    output mreq_t             cur,
    output logic              req_ready,
    output logic              done,
    output logic              err
);
    localparam int RTRY_W = $clog2(MAX_RETRY + 1) + 1;
    localparam logic [TICK_W-1:0] ACK_TK  = TICK_W'(ACK_T);
    localparam logic [TICK_W-1:0] WAIT_TK = TICK_W'(RETRY_WAIT - 1);

    logic [RTRY_W-1:0] retries;
    logic              short_wr;
    logic              burst_end;

    assign req_ready = (phase == PH_IDLE);
    assign short_wr  = (int'(cur.len_m1) + WR_T) <= ACK_T;
    assign burst_end = (tick > ACK_TK) && (cur.write ? last_w : last_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            tick    <= '0;
            retries <= '0;
            cur     <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur     <= req_in;
                        tick    <= '0;
                        retries <= '0;
                        phase   <= PH_ATTEMPT;
                    end
                end
                PH_ATTEMPT: begin
                    tick <= tick + 1'b1;
                    if (tick == ACK_TK) begin
                        if (ack_in != ACK_GOOD) begin
                            if (retries == RTRY_W'(MAX_RETRY)) begin
                                err   <= 1'b1;
                                phase <= PH_IDLE;
                            end else begin
                                phase <= PH_BACKOFF;
                            end
                        end else if (cur.write && short_wr) begin
                            done  <= 1'b1;
                            phase <= PH_IDLE;
                        end
                    end else if (burst_end) begin
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                PH_BACKOFF: begin
                    if (tick == WAIT_TK) begin
                        tick    <= '0;
                        retries <= retries + 1'b1;
                        phase   <= PH_ATTEMPT;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkt_mem_ctrl.sv
module pkt_mem_ctrl
    import pmc_pkg::*;
#(
    parameter int ACK_DLY    = 8,
    parameter int RD_DLY     = 14,
    parameter int WR_OFS     = 2,
    parameter int RETRY_WAIT = 32,
    parameter int MAX_RETRY  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [35:0] req_addr,
    input  logic [7:0]  req_len_m1,
    output logic [7:0]  wr_idx,
    input  logic [7:0]  wr_data,
    output logic        rd_valid,
    output logic [7:0]  rd_idx,
    output logic [7:0]  rd_data,
    output logic        done,
    output logic        err,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    input  logic [7:0]  bus_in,
    input  logic [1:0]  ack_in
);
    localparam int LAST_PKT = PKT_BYTES - 1;
    localparam int ACK_T    = LAST_PKT + ACK_DLY;
    localparam int WR_T     = LAST_PKT + WR_OFS;
    localparam int RD_T     = LAST_PKT + RD_DLY;
    localparam int SPAN     = RD_T + 256;
    localparam int TICK_MAX = (SPAN > RETRY_WAIT) ? SPAN : RETRY_WAIT;
    localparam int TICK_W   = $clog2(TICK_MAX + 1);

    mreq_t             req_in, cur;
    phase_e            phase;
    logic [TICK_W-1:0] tick;
    logic              attempt;
    logic              pkt_drive;
    logic [7:0]        pkt_data;
    logic              w_in, w_last, r_in, r_last;
    logic [7:0]        w_idx, r_idx;

    assign req_in  = '{write: req_write, addr: req_addr, len_m1: req_len_m1};
    assign attempt = (phase == PH_ATTEMPT);

    pmc_seq #(
        .TICK_W(TICK_W), .ACK_T(ACK_T), .WR_T(WR_T),
        .RETRY_WAIT(RETRY_WAIT), .MAX_RETRY(MAX_RETRY)
    ) seq_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
        .ack_in(ack_in), .last_w(w_last), .last_r(r_last),
        .phase(phase), .tick(tick), .cur(cur), .req_ready(req_ready),
        .done(done), .err(err)
    );

    pmc_pkt_tx pkt_i (
        .req(cur), .idx(tick[2:0]),
        .active(attempt && (tick < TICK_W'(PKT_BYTES))),
        .drive(pkt_drive), .data(pkt_data)
    );

    pmc_burst_win #(.TICK_W(TICK_W), .START(WR_T)) wwin_i (
        .tick(tick), .len_m1(cur.len_m1), .en(attempt && cur.write),
        .in_win(w_in), .idx(w_idx), .last(w_last)
    );

    pmc_burst_win #(.TICK_W(TICK_W), .START(RD_T)) rwin_i (
        .tick(tick), .len_m1(cur.len_m1), .en(attempt && !cur.write),
        .in_win(r_in), .idx(r_idx), .last(r_last)
    );

    assign bus_oe   = pkt_drive || w_in;
    assign bus_out  = pkt_drive ? pkt_data : (w_in ? wr_data : 8'h00);
    assign wr_idx   = w_idx;
    assign rd_valid = r_in;
    assign rd_idx   = r_idx;
    assign rd_data  = bus_in;
endmodule

// File: rtl/pkt_mem_ctrl_chk.sv
module pkt_mem_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic err,
    input logic bus_oe,
    input logic rd_valid
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    a_r2_packet_starts: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> bus_oe);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    a_r8_err_not_done: assert property (@(posedge clk) disable iff (rst)
        !(err && done));

    a_r4_read_no_drive: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !bus_oe);
endmodule

bind pkt_mem_ctrl pkt_mem_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .err(err), .bus_oe(bus_oe), .rd_valid(rd_valid)
);

// File: tb/pkt_mem_ctrl_tb_top.sv
module pkt_mem_ctrl_tb_top;
    localparam int MAXR = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [35:0] req_addr = '0;
    logic [7:0]  req_len_m1 = '0;
    logic [7:0]  wr_idx;
    logic [7:0]  wr_data;
    logic        rd_valid;
    logic [7:0]  rd_idx;
    logic [7:0]  rd_data;
    logic        done, err;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  bus_in = '0;
    logic [1:0]  ack_in = '0;
    logic [7:0]  wseed = 8'h11;
    logic [7:0]  rseed = 8'h22;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] wbyte(input logic [7:0] i);
        return 8'(i * 8'd7) + wseed;
    endfunction

    function automatic logic [7:0] rbyte(input int i);
        return 8'(i * 13) ^ rseed;
    endfunction

    assign wr_data = wbyte(wr_idx);

    pkt_mem_ctrl dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issues one request and plays the responder for every attempt.
    task automatic do_txn(input bit wr, input logic [35:0] addr, input int len,
                          input int nacks, input logic [1:0] bad_code);
        logic [7:0] pkt [6];
        int  attempts;
        bit  gives_err;
        bit  pk_ok = 1, wd_ok = 1, rd_ok = 1, quiet_ok = 1, rdy_ok = 1, early_ok = 1;
        longint pk_act = 0;
        gives_err = (nacks > MAXR);
        attempts  = gives_err ? MAXR + 1 : nacks + 1;
        pkt[0] = {wr ? 4'h2 : 4'h1, addr[35:32]};
        pkt[1] = 8'(len - 1);
        pkt[2] = addr[31:24];
        pkt[3] = addr[23:16];
        pkt[4] = addr[15:8];
        pkt[5] = addr[7:0];
        wseed = addr[7:0] ^ 8'h3C;
        rseed = addr[15:8] ^ 8'hA5;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len_m1 = 8'(len - 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int a = 0; a < attempts; a++) begin
            bit pos;
            int tend;
            pos = (a == nacks);
            if (pos) tend = wr ? ((7 + len - 1 > 13) ? 7 + len - 1 : 13) : 19 + len - 1;
            else if (gives_err && a == attempts - 1) tend = 13;
            else tend = 31;
            for (int t = 0; t <= tend; t++) begin
                ack_in = (t == 13) ? (pos ? 2'b01 : bad_code) : 2'b00;
                bus_in = (!wr && pos && t >= 19 && t < 19 + len) ? rbyte(t - 19) : 8'h00;
                #1;
                if (req_ready) rdy_ok = 0;
                if (done || err) early_ok = 0;
                if (t < 6) begin
                    if (!bus_oe || bus_out !== pkt[t]) begin pk_ok = 0; pk_act = bus_out; end
                end else if (wr && t >= 7 && t < 7 + len && (pos || t <= 13)) begin
                    if (!bus_oe || bus_out !== wbyte(8'(t - 7)) || wr_idx !== 8'(t - 7)) wd_ok = 0;
                end else if (bus_oe) quiet_ok = 0;
                if (!wr && pos && t >= 19 && t < 19 + len) begin
                    if (!rd_valid || rd_idx !== 8'(t - 19) || rd_data !== rbyte(t - 19)) rd_ok = 0;
                end else if (rd_valid) rd_ok = 0;
                @(negedge clk);
            end
        end
        ack_in = 2'b00;
        bus_in = 8'h00;
        #1;
        check(pk_ok, "R2", "packet bytes/order", pk_act, pkt[0]);
        check(quiet_ok, "R6", "bus released outside packet/data windows", 0, 0);
        check(rdy_ok, "R1", "req_ready low while busy", 1, 0);
        check(early_ok, "R9", "no early done/err", 1, 0);
        if (wr) check(wd_ok, "R5", "write data timing/index", 0, 1);
        else    check(rd_ok, "R4", "read capture timing/index", 0, 1);
        if (gives_err)
            check(err && !done, "R8", "err pulse after last refusal", {err, done}, 2'b10);
        else
            check(done && !err, "R9", "done pulse after burst", {done, err}, 2'b10);
        check(req_ready, "R1", "idle after completion", req_ready, 1);
        @(negedge clk);
        #1;
        check(!done && !err, "R9", "pulse lasts one cycle", {done, err}, 0);
    endtask

    task automatic t_reset;
        #1;
        check(req_ready && !bus_oe && !done && !err && !rd_valid, "R1",
              "reset state", {req_ready, bus_oe, done, err, rd_valid}, 5'b10000);
    endtask

    task automatic t_read_hit;     do_txn(0, 36'h9_1234_5678, 4, 0, 2'b10); endtask
    task automatic t_write_short;  do_txn(1, 36'h3_0BAD_F00D, 3, 0, 2'b10); endtask
    task automatic t_write_long;   do_txn(1, 36'hF_FFFF_0001, 10, 0, 2'b10); endtask
    task automatic t_read_retry;   do_txn(0, 36'h0_00C0_FFEE, 5, 2, 2'b10); endtask // R7
    task automatic t_write_retry;  do_txn(1, 36'h5_5555_AAAA, 20, 1, 2'b10); endtask // R6 R7
    task automatic t_code_11;      do_txn(0, 36'h7_1357_9BDF, 2, 1, 2'b11); endtask // R3
    task automatic t_retry_limit;  do_txn(0, 36'hA_2468_ACE0, 6, 4, 2'b10); endtask // R8
    task automatic t_len_max;      do_txn(0, 36'h1_0000_0100, 256, 0, 2'b10); endtask // R10
    task automatic t_len_one;      do_txn(1, 36'h2_0000_0200, 1, 0, 2'b10); endtask // R10

    task automatic t_ack_late_window;
        // R3: a positive code one cycle before the slot followed by 00 in the slot is refused.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 36'h4_4444_4444; req_len_m1 = 8'd0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        ack_in = 2'b01;
        @(negedge clk);
        ack_in = 2'b00;
        repeat (7) @(negedge clk);
        #1;
        check(!rd_valid && !bus_oe, "R3", "no data without ack in slot",
              {rd_valid, bus_oe}, 0);
        repeat (12) @(negedge clk);
        #1;
        check(bus_oe && bus_out == 8'h14, "R7", "reissue byte0 at retry wait", bus_out, 8'h14);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready && !bus_oe, "R1", "idle after reset", {req_ready, bus_oe}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_hit();
        t_write_short();
        t_write_long();
        t_read_retry();
        t_write_retry();
        t_code_11();
        t_retry_limit();
        t_len_max();
        t_len_one();
        t_ack_late_window();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule